// File: doc/BRIEF.md
# Address-Masked APB GPIO Port

This block is an eight-pin general-purpose I/O port behind an APB slave. Each pin has a direction bit and an output data bit. The pin inputs are brought into the bus clock domain through a multi-flop synchronizer, and software reads them from the same data window it writes through.

Access to the data register goes through a 1 KiB window that starts at offset 0. The word address inside that window, paddr[9:2], is an eight-bit mask with one bit per pin. A read returns only the masked pins and returns 0 for the rest. A write changes only the masked output bits and leaves the others as they were. Software can therefore drive or sample any subset of pins in one bus access, with no read-modify-write and no race between independent users of different pins.

The direction register at offset 0x400 is read and written as a whole byte. The bus has no wait states and never signals an error.

Top module: `gpio_masked_apb`

## Requirements
- R1: After reset, gpio_out and gpio_oe are both 0x00, so every pin is an input.
- R2: pready is always 1 and pslverr is always 0.
- R3: A read at an offset in 0x000..0x3FC uses mask = paddr[9:2]. prdata[n] is the pin value for each n whose mask bit is 1, and 0 for each n whose mask bit is 0.
- R4: A write at an offset in 0x000..0x3FC with mask = paddr[9:2] sets gpio_out[n] to pwdata[n] where the mask bit is 1, and leaves gpio_out[n] unchanged where it is 0.
- R5: A write to offset 0x400 loads pwdata[7:0] into the direction register. gpio_oe equals that register, with bit n = 1 making pin n an output. A read of 0x400 returns the register in prdata[7:0].
- R6: In a data read, the value of a pin whose direction bit is 1 is its output register bit. The value of a pin whose direction bit is 0 is its synchronized input. The output register keeps its value while the pin is an input.
- R7: A change on gpio_in shows in data reads after exactly two rising pclk edges. It does not show after one.
- R8: Reads of any other offset (0x404 up, including 0x800..0xFFF) return 0. Writes to those offsets change neither gpio_out nor gpio_oe.
- R9: Only pwdata[7:0] is used. prdata[31:8] is always 0.
- R10: A write takes effect only in the access phase (psel, penable and pwrite all 1). A setup phase on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Constant 1 |
| pslverr | output | 1 | Constant 0 |
| gpio_in | input | 8 | Pin input levels, asynchronous |
| gpio_out | output | 8 | Pin output values |
| gpio_oe | output | 8 | Pin output enables |

## Verification
The masked write is tried with the full mask, with single-bit masks at the lowest and a middle pin, and with the empty mask. Together these show whether the mask gates each bit on its own, and whether address bit 2 lines up with pin 0. Masked reads use complementary nibble and split masks against a fixed input pattern, which shows that each bit is gated by its own mask bit and not by some shifted one. A mixed direction setting, with output register and pin levels chosen to disagree, tells the loopback path apart from the pin path. A held read around one input edge pins the synchronizer delay to the exact cycle. Undecoded offsets, upper data bits and a setup phase with no access phase show which accesses the decode must ignore.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
   localparam int unsigned PIN_CNT  = 8;
   localparam int unsigned MASK_LSB = 2;
   localparam int unsigned DIR_OFF  = 1 << (PIN_CNT + MASK_LSB);

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2
   } rgn_e;

   typedef logic [PIN_CNT-1:0] pins_t;
endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
   import gpio_mask_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output rgn_e              region,
   output pins_t             mask,
   output logic              wr_stb
);
   localparam int unsigned TOP_LSB = PIN_CNT + MASK_LSB;
   localparam int unsigned WORD_W  = ADDR_W - MASK_LSB;
   localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFF >> MASK_LSB);

   if (ADDR_W <= TOP_LSB) begin : g_bad_addr_w
      $error("ADDR_W too small to hold the direction offset");
   end

   logic in_data;
   logic in_dir;

   assign in_data = (paddr[ADDR_W-1:TOP_LSB] == '0);
   assign in_dir  = (paddr[ADDR_W-1:MASK_LSB] == DIR_WORD);
   assign mask    = paddr[TOP_LSB-1:MASK_LSB];
   assign wr_stb  = psel & penable & pwrite;

   always_comb begin
      if (in_data)     region = RGN_DATA;
      else if (in_dir) region = RGN_DIR;
      else             region = RGN_NONE;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
   import gpio_mask_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_stb,
   input  rgn_e  region,
   input  pins_t mask,
   input  pins_t wdata,
   input  pins_t pin_sync,
   output pins_t out_q,
   output pins_t dir_q,
   output pins_t level
);
   logic data_we;
   logic dir_we;

   assign data_we = wr_stb && (region == RGN_DATA);
   assign dir_we  = wr_stb && (region == RGN_DIR);

   for (genvar n = 0; n < PIN_CNT; n++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   out_q[n] <= 1'b0;
         else if (data_we && mask[n])  out_q[n] <= wdata[n];
      end
      assign level[n] = dir_q[n] ? out_q[n] : pin_sync[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end
endmodule

// File: rtl/gpio_masked_apb.sv
module gpio_masked_apb
   import gpio_mask_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [7:0]        gpio_in,
   output logic [7:0]        gpio_out,
   output logic [7:0]        gpio_oe
);
   if (DATA_W < PIN_CNT) begin : g_bad_data_w
      $error("DATA_W must cover all pins");
   end

   rgn_e  region;
   pins_t mask;
   logic  wr_stb;
   pins_t pin_sync;
   pins_t out_q;
   pins_t dir_q;
   pins_t level;
   pins_t rd_byte;

   gpio_apb_decode #(.ADDR_W(ADDR_W)) u_decode (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .region  (region),
      .mask    (mask),
      .wr_stb  (wr_stb)
   );

   gpio_in_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (pclk),
      .rst_n    (presetn),
      .async_in (gpio_in),
      .sync_out (pin_sync)
   );

   gpio_pin_regs u_regs (
      .clk      (pclk),
      .rst_n    (presetn),
      .wr_stb   (wr_stb),
      .region   (region),
      .mask     (mask),
      .wdata    (pwdata[PIN_CNT-1:0]),
      .pin_sync (pin_sync),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .level    (level)
   );

   always_comb begin
      unique case (region)
         RGN_DATA: rd_byte = level & mask;
         RGN_DIR:  rd_byte = dir_q;
         default:  rd_byte = '0;
      endcase
   end

   assign prdata   = {{(DATA_W-PIN_CNT){1'b0}}, rd_byte};
   assign pready   = 1'b1;
   assign pslverr  = 1'b0;
   assign gpio_out = out_q;
   assign gpio_oe  = dir_q;
endmodule

// File: rtl/gpio_masked_apb_chk.sv
module gpio_masked_apb_chk (
   input logic        pclk,
   input logic        presetn,
   input logic        psel,
   input logic        penable,
   input logic        pwrite,
   input logic [11:0] paddr,
   input logic [31:0] pwdata,
   input logic [31:0] prdata,
   input logic        pready,
   input logic        pslverr,
   input logic [7:0]  gpio_out,
   input logic [7:0]  gpio_oe
);
   logic       acc_wr;
   logic       in_data;
   logic       in_dir;
   logic [7:0] amask;

   assign acc_wr  = psel && penable && pwrite;
   assign in_data = (paddr[11:10] == 2'b00);
   assign in_dir  = (paddr[11:2] == 10'h100);
   assign amask   = paddr[9:2];

   // R2
   p_bus_ok_r2: assert property (@(posedge pclk) disable iff (!presetn)
      pready && !pslverr);

   // R3
   p_read_mask_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && in_data) |-> ((prdata[7:0] & ~amask) == 8'h00));

   // R4
   p_write_mask_r4: assert property (@(posedge pclk) disable iff (!presetn)
      (acc_wr && in_data) |=>
         gpio_out == (($past(gpio_out) & ~$past(amask)) |
                      ($past(pwdata[7:0]) & $past(amask))));

   // R5
   p_dir_load_r5: assert property (@(posedge pclk) disable iff (!presetn)
      (acc_wr && in_dir) |=> gpio_oe == $past(pwdata[7:0]));

   // R8 and R10
   p_hold_r8: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc_wr && (in_data || in_dir)) |=> ($stable(gpio_out) && $stable(gpio_oe)));

   // R9
   p_upper_zero_r9: assert property (@(posedge pclk) disable iff (!presetn)
      prdata[31:8] == 24'h0);
endmodule

bind gpio_masked_apb gpio_masked_apb_chk u_chk (
   .pclk     (pclk),
   .presetn  (presetn),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .prdata   (prdata),
   .pready   (pready),
   .pslverr  (pslverr),
   .gpio_out (gpio_out),
   .gpio_oe  (gpio_oe)
);

// File: tb/test_gpio_masked_apb.sv
`timescale 1ns/1ps
module test_gpio_masked_apb;
   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [7:0]  gpio_in = '0;
   logic [7:0]  gpio_out;
   logic [7:0]  gpio_oe;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 pclk = ~pclk;

   gpio_masked_apb i_gpio_masked_apb (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .gpio_in(gpio_in),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #0.5;
      d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 gpio_out", {24'h0, gpio_out}, 32'h0);
      check("R1 gpio_oe", {24'h0, gpio_oe}, 32'h0);
      check("R2 pready", {31'h0, pready}, 32'h1);
      check("R2 pslverr", {31'h0, pslverr}, 32'h0);
      apb_read(12'h400, d);
      check("R1 dir readback", d, 32'h0);
   endtask

   task automatic t_direction();
      logic [31:0] d;
      apb_write(12'h400, 32'h0000_00F0);
      check("R5 gpio_oe", {24'h0, gpio_oe}, 32'hF0);
      apb_read(12'h400, d);
      check("R5 dir readback", d, 32'h0000_00F0);
      apb_write(12'h400, 32'hFFFF_FF0F);
      check("R9 upper wdata ignored", {24'h0, gpio_oe}, 32'h0F);
      apb_read(12'h400, d);
      check("R9 prdata upper zero", d, 32'h0000_000F);
   endtask

   task automatic t_mask_write();
      logic [31:0] d;
      apb_write(12'h400, 32'hFF);
      apb_write(12'h3FC, 32'hA5);
      check("R4 full mask", {24'h0, gpio_out}, 32'hA5);
      apb_write(12'h004, 32'h00);
      check("R4 mask bit0", {24'h0, gpio_out}, 32'hA4);
      apb_write(12'h100, 32'hFF);
      check("R4 mask bit6", {24'h0, gpio_out}, 32'hE4);
      apb_write(12'h000, 32'hFF);
      check("R4 empty mask", {24'h0, gpio_out}, 32'hE4);
      apb_read(12'h03C, d);
      check("R3 R6 low nibble of outputs", d, 32'h04);
   endtask

   task automatic t_input_read();
      logic [31:0] d;
      apb_write(12'h400, 32'h00);
      gpio_in = 8'h3C;
      repeat (4) @(negedge pclk);
      apb_read(12'h3FC, d);
      check("R3 full mask input", d, 32'h3C);
      apb_read(12'h0C0, d);
      check("R3 mask 0x30", d, 32'h30);
      apb_read(12'h30C, d);
      check("R3 mask 0xC3", d, 32'h00);
      check("R6 out kept while input", {24'h0, gpio_out}, 32'hE4);
   endtask

   task automatic t_mixed();
      logic [31:0] d;
      apb_write(12'h400, 32'h0F);
      gpio_in = 8'hA3;
      repeat (4) @(negedge pclk);
      apb_read(12'h3FC, d);
      check("R6 mixed direction", d, 32'hA4);
   endtask

   task automatic t_sync_delay();
      apb_write(12'h400, 32'h00);
      gpio_in = 8'h00;
      repeat (4) @(negedge pclk);
      psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 12'h3FC;
      @(negedge pclk);
      check("R7 before edge", prdata, 32'h00);
      gpio_in = 8'hFF;
      @(negedge pclk);
      check("R7 after one edge", prdata, 32'h00);
      @(negedge pclk);
      check("R7 after two edges", prdata, 32'hFF);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic t_undecoded();
      logic [31:0] d;
      apb_write(12'h404, 32'hFF);
      apb_write(12'h800, 32'hFF);
      apb_write(12'hBFC, 32'hFF);
      check("R8 oe unchanged", {24'h0, gpio_oe}, 32'h00);
      check("R8 out unchanged", {24'h0, gpio_out}, 32'hE4);
      apb_read(12'h404, d);
      check("R8 read 0x404", d, 32'h0);
      apb_read(12'hFFC, d);
      check("R8 read 0xFFC", d, 32'h0);
   endtask

   task automatic t_setup_only();
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 32'h00;
      @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      @(negedge pclk);
      check("R10 setup only data", {24'h0, gpio_out}, 32'hE4);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h400; pwdata = 32'hFF;
      @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      @(negedge pclk);
      check("R10 setup only dir", {24'h0, gpio_oe}, 32'h00);
   endtask

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);
      t_reset();
      t_direction();
      t_mask_write();
      t_input_read();
      t_mixed();
      t_sync_delay();
      t_undecoded();
      t_setup_only();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge pclk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule